// File: doc/BRIEF.md
# I2C Double-Buffered Data Register

This block sits between a processor's data-register access and an I2C byte shifter. Software loads transmit bytes into a small queue and collects received bytes from a holding register. It never has to wait for the byte in flight to finish. The shifter takes bytes and delivers bytes on its own schedule, so register access timing never holds up the bus.

An availability flag tells software when a transmit write will be accepted. A transfer-complete flag marks each finished byte. Sticky error bits record writes that were refused and bytes the shifter needed that software had not yet supplied. A direction latch keeps the read/write bit of the most recent address match. A wake-up arming control lets a write-direction address match produce a single wake pulse.

Top module: `i2c_dbuf`

## Requirements
- R1: After a synchronous reset, or in the cycle after `stop_det` is high, the transmit queue is empty, `tx_room` is 1, and `xfer_done`, `wr_overrun` and `tx_underrun` are 0.
- R2: Accepted transmit bytes appear on `tx_byte` in the order they were written. Each `tx_take` pulse removes the byte shown, and `tx_byte` is a function of queue state only.
- R3: `tx_room` is 1 when the queue holds no byte. It is also 1 when the queue holds one byte and the frame's double-write allowance is unused. Otherwise it is 0.
- R4: An address match (`adr_hit`) grants one double-write allowance. A write into the second slot uses it up, and `stop_det` withdraws it.
- R5: A write while `tx_room` is 0 is refused and leaves the queue unchanged. It sets `wr_overrun`, which stays set until reset or STOP.
- R6: `xfer_done` is 1 in the cycle after `byte_done`. It is cleared in the cycle after any `reg_rd` or `reg_wr`. When `byte_done` and an access coincide, the set wins.
- R7: `rx_load` captures `rx_byte` into the holding register, which drives `reg_rdata`. Any number of reads return the same byte and leave it unchanged.
- R8: A `tx_take` while the queue is empty sees `tx_byte` = 8'hFF and sets `tx_underrun`, which stays set until reset or STOP.
- R9: `dir_rd` takes the read/write bit (1 = read) of each address match in the following cycle. Reset clears it, and STOP leaves it unchanged.
- R10: `lp_arm` arms wake-up only while `dir_rd` is 0 and no address match occurs in the same cycle. While armed, a match with the write bit sets `wake` for exactly one cycle and disarms. A match with the read bit never sets `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_det | input | 1 | STOP condition seen on the bus |
| reg_wr | input | 1 | Data-register write strobe |
| reg_rd | input | 1 | Data-register read strobe |
| reg_wdata | input | 8 | Data written by software |
| reg_rdata | output | 8 | Held received byte |
| tx_room | output | 1 | A transmit write will be accepted |
| xfer_done | output | 1 | Byte transfer complete flag |
| wr_overrun | output | 1 | Sticky refused-write flag |
| tx_underrun | output | 1 | Sticky empty-take flag |
| tx_take | input | 1 | Shifter takes the byte on `tx_byte` |
| tx_byte | output | 8 | Next transmit byte, 8'hFF when empty |
| byte_done | input | 1 | Shifter finished a byte |
| rx_load | input | 1 | Shifter presents a received byte |
| rx_byte | input | 8 | Received byte |
| adr_hit | input | 1 | Own address matched |
| adr_dir | input | 1 | Read/write bit of the match, 1 = read |
| lp_arm | input | 1 | Request to arm wake-up |
| dir_rd | output | 1 | Latched direction of the last match |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
Every flag and the held receive byte are registered, so each one reflects a strobe exactly one clock edge after the strobe. `tx_byte` and `tx_room` are combinational from registered state and change in the same cycle the state does. The bench drives each strobe for one cycle and samples one time unit after the next rising edge. At that point all one-edge results are settled and no further edge has passed. Transmit bytes are checked against an in-bench queue and availability model, compared at each take.

// File: rtl/i2cdb_pkg.sv
package i2cdb_pkg;

    typedef struct packed {
        logic tcf;
        logic ovr;
        logic udr;
        logic dbl;
    } flags_t;

    typedef struct packed {
        logic srw;
        logic armed;
        logic wake;
    } wake_t;

endpackage

// File: rtl/i2cdb_txq.sv
module i2cdb_txq #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          push,
    input  logic [DW-1:0]                 wdata,
    input  logic                          pop,
    output logic [DW-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } st_t;

    st_t st_d, st_q;
    logic do_pop, do_push;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_pop) st_d.rd = nxt(st_q.rd);
        if (do_push) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr           = nxt(st_q.wr);
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

    p_no_push_full_r5: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (st_q.cnt != CW'(DEPTH)));
    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CW'(DEPTH));

endmodule

// File: rtl/i2cdb_rxhold.sv
module i2cdb_rxhold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] hold
);
    logic [DW-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) hold_d = din;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign hold = hold_q;

    p_rx_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold_q));

endmodule

// File: rtl/i2cdb_wake.sv
module i2cdb_wake
    import i2cdb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adr_hit,
    input  logic adr_dir,
    input  logic lp_arm,
    output logic dir_rd,
    output logic wake
);
    wake_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (adr_hit) begin
            st_d.srw = adr_dir;
            if (st_q.armed && !adr_dir) begin
                st_d.wake  = 1'b1;
                st_d.armed = 1'b0;
            end
        end else if (lp_arm && !st_q.srw) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dir_rd = st_q.srw;
    assign wake   = st_q.wake;

    p_srw_follow_r9: assert property (@(posedge clk) disable iff (rst)
        adr_hit |=> (dir_rd == $past(adr_dir)));
    p_no_wake_read_r10: assert property (@(posedge clk) disable iff (rst)
        (adr_hit && adr_dir) |=> !wake);
    p_wake_single_r10: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

endmodule

// File: rtl/i2c_dbuf.sv
module i2c_dbuf
    import i2cdb_pkg::*;
#(
    parameter int DW  = 8,
    parameter int TXD = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stop_det,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          tx_room,
    output logic          xfer_done,
    output logic          wr_overrun,
    output logic          tx_underrun,
    input  logic          tx_take,
    output logic [DW-1:0] tx_byte,
    input  logic          byte_done,
    input  logic          rx_load,
    input  logic [DW-1:0] rx_byte,
    input  logic          adr_hit,
    input  logic          adr_dir,
    input  logic          lp_arm,
    output logic          dir_rd,
    output logic          wake
);
    localparam int            CW   = $clog2(TXD + 1);
    localparam logic [DW-1:0] FILL = {DW{1'b1}};
    localparam logic [CW-1:0] LAST = CW'(TXD - 1);

    flags_t        fl_d, fl_q;
    logic [CW-1:0] q_cnt;
    logic [DW-1:0] q_head;
    logic          wr_ok;
    logic          q_empty;

    assign q_empty = (q_cnt == '0);
    assign tx_room = (q_cnt < LAST) || ((q_cnt == LAST) && fl_q.dbl);
    assign wr_ok   = reg_wr && tx_room;

    i2cdb_txq #(.DW(DW), .DEPTH(TXD)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (stop_det),
        .push  (wr_ok),
        .wdata (reg_wdata),
        .pop   (tx_take),
        .head  (q_head),
        .count (q_cnt)
    );

    i2cdb_rxhold #(.DW(DW)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .load (rx_load),
        .din  (rx_byte),
        .hold (reg_rdata)
    );

    i2cdb_wake u_wake (
        .clk     (clk),
        .rst     (rst),
        .adr_hit (adr_hit),
        .adr_dir (adr_dir),
        .lp_arm  (lp_arm),
        .dir_rd  (dir_rd),
        .wake    (wake)
    );

    always_comb begin
        fl_d = fl_q;
        if (byte_done)            fl_d.tcf = 1'b1;
        else if (reg_rd || reg_wr) fl_d.tcf = 1'b0;
        if (reg_wr && !tx_room)   fl_d.ovr = 1'b1;
        if (tx_take && q_empty)   fl_d.udr = 1'b1;
        if (adr_hit)              fl_d.dbl = 1'b1;
        else if (wr_ok && (q_cnt == LAST)) fl_d.dbl = 1'b0;
        if (stop_det)             fl_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '0;
        else     fl_q <= fl_d;
    end

    assign tx_byte     = q_empty ? FILL : q_head;
    assign xfer_done   = fl_q.tcf;
    assign wr_overrun  = fl_q.ovr;
    assign tx_underrun = fl_q.udr;

    p_tcf_set_r6: assert property (@(posedge clk) disable iff (rst || stop_det)
        byte_done |=> xfer_done);
    p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (rst || stop_det)
        wr_overrun |=> wr_overrun);
    p_udr_set_r8: assert property (@(posedge clk) disable iff (rst || stop_det)
        (tx_take && q_empty) |=> tx_underrun);
    p_full_no_room_r3: assert property (@(posedge clk) disable iff (rst)
        (q_cnt == CW'(TXD)) |-> !tx_room);
    p_stop_clear_r1: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (tx_room && !xfer_done && !wr_overrun && !tx_underrun));

endmodule

// File: tb/i2c_dbuf_tb_top.sv
module i2c_dbuf_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_det = 0, reg_wr = 0, reg_rd = 0, tx_take = 0;
    logic       byte_done = 0, rx_load = 0, adr_hit = 0, adr_dir = 0, lp_arm = 0;
    logic [7:0] reg_wdata = 0, rx_byte = 0;
    logic [7:0] reg_rdata, tx_byte;
    logic       tx_room, xfer_done, wr_overrun, tx_underrun, dir_rd, wake;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] sb[$];
    int  m_cnt = 0;
    bit  m_dbl = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_dbuf dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        {stop_det, reg_wr, reg_rd, tx_take, byte_done, rx_load, adr_hit, lp_arm} = '0;
    endtask

    task automatic wr(input logic [7:0] b);
        if (m_cnt == 0 || (m_cnt == 1 && m_dbl)) begin
            sb.push_back(b);
            if (m_cnt == 1) m_dbl = 0;
            m_cnt++;
        end
        reg_wr = 1; reg_wdata = b; cyc(); idle();
    endtask

    // monitor side of the scoreboard: compare the byte the shifter sees
    task automatic take();
        logic [7:0] e;
        if (sb.size() > 0) begin e = sb.pop_front(); m_cnt--; end
        else e = 8'hFF;
        chk("R2/R8 tx_byte", tx_byte, e);
        tx_take = 1; cyc(); idle();
    endtask

    task automatic adr(input logic rw);
        m_dbl = 1;
        adr_hit = 1; adr_dir = rw; cyc(); idle();
    endtask

    task automatic room_chk(input string tag);
        chk(tag, tx_room, (m_cnt == 0) || (m_cnt == 1 && m_dbl));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 room", tx_room, 1); chk("R1 tcf", xfer_done, 0);
        chk("R1 ovr", wr_overrun, 0); chk("R1 udr", tx_underrun, 0);
        chk("R9 srw reset", dir_rd, 0); chk("R10 wake reset", wake, 0);

        // R4 allowance from address match, R3 room tracking
        adr(0);
        chk("R9 srw write", dir_rd, 0);
        wr(8'hA1); room_chk("R3 one byte with allowance");
        wr(8'hA2); room_chk("R4 allowance used");
        chk("R3 full", tx_room, 0);
        wr(8'hA3); chk("R5 ovr set", wr_overrun, 1);
        take(); room_chk("R4 no allowance after use");
        take(); room_chk("R3 empty");
        chk("R5 ovr sticky", wr_overrun, 1);
        take(); chk("R8 udr", tx_underrun, 1);

        // R6 completion flag
        byte_done = 1; cyc(); idle(); chk("R6 set", xfer_done, 1);
        reg_rd = 1; cyc(); idle(); chk("R6 dummy read clears", xfer_done, 0);
        byte_done = 1; cyc(); idle();
        wr(8'hB1); chk("R6 write clears", xfer_done, 0);
        byte_done = 1; reg_rd = 1; cyc(); idle(); chk("R6 set wins", xfer_done, 1);

        // R5 second write without allowance refused
        room_chk("R3 one byte no allowance");
        wr(8'hB2); chk("R5 refused", wr_overrun, 1);
        take(); take();

        // R1 STOP clears flags and queue
        wr(8'hC1);
        stop_det = 1; cyc(); idle();
        sb.delete(); m_cnt = 0; m_dbl = 0;
        chk("R1 stop room", tx_room, 1); chk("R1 stop tcf", xfer_done, 0);
        chk("R1 stop ovr", wr_overrun, 0); chk("R1 stop udr", tx_underrun, 0);
        chk("R1 stop tx_byte", tx_byte, 8'hFF);
        wr(8'hD4); wr(8'hD5); chk("R5 no allowance after stop", wr_overrun, 1);
        take(); take();

        // R7 receive holding
        rx_byte = 8'h5A; rx_load = 1; cyc(); idle();
        chk("R7 load", reg_rdata, 8'h5A);
        reg_rd = 1; cyc(); idle(); chk("R7 read1", reg_rdata, 8'h5A);
        reg_rd = 1; cyc(); idle(); chk("R7 read2", reg_rdata, 8'h5A);
        rx_byte = 8'hC3; rx_load = 1; cyc(); idle(); chk("R7 reload", reg_rdata, 8'hC3);

        // R9 / R10 direction and wake
        adr(1); chk("R9 srw read", dir_rd, 1);
        lp_arm = 1; cyc(); idle();
        adr(0); chk("R10 arm refused while read", wake, 0);
        chk("R9 srw back to write", dir_rd, 0);
        lp_arm = 1; cyc(); idle();
        adr(1); chk("R10 read match no wake", wake, 0);
        adr(0); chk("R10 wake pulse", wake, 1);
        cyc(); chk("R10 wake one cycle", wake, 0);
        adr(0); chk("R10 disarmed", wake, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule